// File: doc/BRIEF.md
# Word Sync Sequence Inserter

This block sits in one transmit lane, just in front of the line. It runs on the bit clock and divides it by ten to form character slots. At the last bit of each slot it decides which 10-bit character comes next. That character is either a pre-encoded data code supplied by an upstream 8b/10b encoder or a member of a word-sync run. It then shifts the character out one bit per clock. The block tracks the lane's running disparity across both kinds of character and presents it to the encoder, so the encoder can pick the right code form.

A sync request sampled at a slot boundary starts a run of sixteen K28.5 comma characters. The receiver uses this run to align lanes. The run breaks the usual K28.5 alternation: the second and fourth characters repeat the polarity of the character before them. The whole run therefore depends on the disparity in force when it begins. While a run is in progress, the request, the payload byte, the control flag and the encoder code are all ignored. If the request is still high when a run ends, a new run follows with no gap.

Top module: `wsync_inserter`

## Requirements
- R1: While reset is asserted and in the first slot after it, the running disparity is negative (`enc_rd_pos` = 0), no run is active, and `ser_out` carries the negative-disparity K28.5 code 10'h17C.
- R2: `char_take` is high for exactly one clock in every ten, on the last bit of the current character. The inputs are sampled on that clock.
- R3: A character is a 10-bit vector whose bit 0 (code bit a) goes out first. Bit i of the character chosen at a take edge appears on `ser_out` during the (i+1)-th clock after that edge.
- R4: A data character sends `enc_code` unchanged. The running disparity toggles after it exactly when `enc_flip` was high at the take.
- R5: `sync_req` high at a take, with no run active, starts a run. The first run character uses the running disparity in force at that take.
- R6: A run is 16 K28.5 characters: 10'h17C at negative polarity and 10'h283 at positive polarity. With starting polarity r, the polarity sequence is r, r, ~r, ~r, then r and ~r alternating up to the 16th character.
- R7: Inside a run, and in the slot that starts it, `sync_req`, `tx_byte`, `tx_k`, `enc_code` and `enc_flip` have no effect on the line. `enc_byte` and `enc_k` are forced to 0.
- R8: Each run character leaves the running disparity opposite to its own polarity. After a full run, the disparity therefore equals its value when the run started.
- R9: At the take that follows the 16th run character, `sync_req` high starts a new run at once. `sync_req` low sends a data character.
- R10: `enc_rd_pos` always shows the running disparity that applies to the next character chosen (1 = positive).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_req | input | 1 | Word-sync run request, sampled at `char_take` |
| tx_byte | input | 8 | Payload byte from the source |
| tx_k | input | 1 | Control/data flag from the source |
| enc_code | input | 10 | Pre-encoded 10-bit code from the encoder, bit 0 sent first |
| enc_flip | input | 1 | Encoder marks `enc_code` as unbalanced |
| enc_byte | output | 8 | Payload forwarded to the encoder, zero in sync slots |
| enc_k | output | 1 | Control flag forwarded to the encoder, zero in sync slots |
| enc_rd_pos | output | 1 | Current running disparity, 1 = positive |
| char_take | output | 1 | Slot boundary: inputs are consumed this clock |
| ser_out | output | 1 | Serial line output |

## Verification
The hardest state to reach from the ports is a run that starts at positive disparity. Reset always leaves the lane negative. The stimulus first sends an unbalanced data character with `enc_flip` high, then raises the request, so the mirrored pattern is exercised. Held and toggling requests inside a run check that mid-run requests are ignored. A request held high through the final slot checks that the next run follows with no gap.

// File: rtl/wsync_inserter.sv
module wsync_inserter #(
  parameter int CW       = 10,
  parameter int BW       = 8,
  parameter int RUN_LEN  = 16,
  parameter logic [CW-1:0] K_NEG = 10'h17C,
  parameter logic [CW-1:0] K_POS = 10'h283
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync_req,
  input  logic [BW-1:0] tx_byte,
  input  logic          tx_k,
  input  logic [CW-1:0] enc_code,
  input  logic          enc_flip,
  output logic [BW-1:0] enc_byte,
  output logic          enc_k,
  output logic          enc_rd_pos,
  output logic          char_take,
  output logic          ser_out
);
  localparam int BCW = $clog2(CW);
  localparam int SW  = $clog2(RUN_LEN);

  logic [BCW-1:0] bcnt;
  logic [CW-1:0]  shreg;
  logic           rd;
  logic           busy;
  logic [SW-1:0]  slot;

  logic          sync_sel, force_rep, k_pol, next_rd;
  logic [SW-1:0] idx;
  logic [CW-1:0] k_char, next_char;

  assign char_take  = (bcnt == BCW'(CW - 1));
  assign sync_sel   = busy | sync_req;
  assign idx        = busy ? slot : '0;
  // repeat slots: second and fourth run characters keep the previous polarity
  assign force_rep  = (idx == SW'(1)) | (idx == SW'(3));
  assign k_pol      = rd ^ force_rep;
  assign k_char     = k_pol ? K_POS : K_NEG;
  assign next_char  = sync_sel ? k_char : enc_code;
  assign next_rd    = sync_sel ? ~k_pol : (rd ^ enc_flip);
  assign enc_byte   = sync_sel ? '0 : tx_byte;
  assign enc_k      = sync_sel ? 1'b0 : tx_k;
  assign enc_rd_pos = rd;
  assign ser_out    = shreg[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bcnt  <= '0;
      shreg <= K_NEG;
      rd    <= 1'b0;
      busy  <= 1'b0;
      slot  <= '0;
    end else if (char_take) begin
      bcnt  <= '0;
      shreg <= next_char;
      rd    <= next_rd;
      if (busy) begin
        slot <= (slot == SW'(RUN_LEN - 1)) ? '0 : slot + SW'(1);
        busy <= (slot != SW'(RUN_LEN - 1));
      end else if (sync_req) begin
        slot <= SW'(1);
        busy <= 1'b1;
      end
    end else begin
      bcnt  <= bcnt + BCW'(1);
      shreg <= {1'b0, shreg[CW-1:1]};
    end
  end
endmodule

// File: rtl/wsync_inserter_chk.sv
module wsync_inserter_chk #(
  parameter int CW = 10,
  parameter int SW = 4,
  parameter logic [CW-1:0] K_NEG = 10'h17C,
  parameter logic [CW-1:0] K_POS = 10'h283
) (
  input logic          clk,
  input logic          rst_n,
  input logic          char_take,
  input logic          enc_rd_pos,
  input logic          sync_req,
  input logic          enc_flip,
  input logic          busy,
  input logic [SW-1:0] slot,
  input logic [CW-1:0] shreg
);
  a_r2_take_single: assert property (@(posedge clk) disable iff (!rst_n)
    char_take |=> !char_take);

  a_r10_rd_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !char_take |=> $stable(enc_rd_pos));

  a_r4_data_rd: assert property (@(posedge clk) disable iff (!rst_n)
    (char_take && !busy && !sync_req) |=> (enc_rd_pos == ($past(enc_rd_pos) ^ $past(enc_flip))));

  a_r6_k_codes: assert property (@(posedge clk) disable iff (!rst_n)
    (char_take && (busy || sync_req)) |=> (shreg == K_NEG || shreg == K_POS));

  a_r6_repeat_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (char_take && busy && (slot == SW'(1) || slot == SW'(3))) |=> (enc_rd_pos == $past(enc_rd_pos)));

  a_r7_slot_step: assert property (@(posedge clk) disable iff (!rst_n)
    (char_take && busy) |=> (slot == $past(slot) + SW'(1)));
endmodule

bind wsync_inserter wsync_inserter_chk #(.CW(CW), .SW(SW), .K_NEG(K_NEG), .K_POS(K_POS)) u_chk (
  .clk(clk), .rst_n(rst_n), .char_take(char_take), .enc_rd_pos(enc_rd_pos),
  .sync_req(sync_req), .enc_flip(enc_flip), .busy(busy), .slot(slot), .shreg(shreg)
);

// File: tb/wsync_inserter_bench.sv
module wsync_inserter_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       sync_req = 1'b0;
  logic [7:0] tx_byte = '0;
  logic       tx_k = 1'b0;
  logic [9:0] enc_code = '0;
  logic       enc_flip = 1'b0;
  logic [7:0] enc_byte;
  logic       enc_k, enc_rd_pos, char_take, ser_out;

  wsync_inserter u_wsync_inserter (
    .clk(clk), .rst_n(rst_n), .sync_req(sync_req), .tx_byte(tx_byte), .tx_k(tx_k),
    .enc_code(enc_code), .enc_flip(enc_flip), .enc_byte(enc_byte), .enc_k(enc_k),
    .enc_rd_pos(enc_rd_pos), .char_take(char_take), .ser_out(ser_out)
  );

  int n_chk = 0, n_fail = 0;
  bit exp_rd;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit kpol(input int k, input bit r);
    if (k < 2) return r;
    if (k < 4) return ~r;
    return ((k - 4) % 2 == 0) ? r : ~r;
  endfunction

  function automatic logic [9:0] kcode(input bit p);
    return p ? 10'h283 : 10'h17C;
  endfunction

  task automatic xfer(input bit req, input logic [7:0] b, input bit k, input logic [9:0] code,
                      input bit fl, output logic [9:0] got, output bit rd0, output bit eb_zero);
    while (!char_take) @(negedge clk);
    sync_req = req; tx_byte = b; tx_k = k; enc_code = code; enc_flip = fl;
    #1;
    rd0 = enc_rd_pos;
    eb_zero = (enc_byte == 8'h00) && (enc_k == 1'b0);
    @(posedge clk);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      got[i] = ser_out;
    end
  endtask

  task automatic t_reset();
    logic [9:0] got;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(enc_rd_pos == 1'b0, "R1", "rd in reset", enc_rd_pos, 0);
    rst_n = 1'b1;
    got[0] = ser_out;
    for (int i = 1; i < 10; i++) begin
      @(negedge clk);
      got[i] = ser_out;
    end
    chk(got == 10'h17C, "R1", "idle char", got, 10'h17C);
    chk(char_take == 1'b1, "R2", "take on last bit", char_take, 1);
    exp_rd = 1'b0;
  endtask

  task automatic t_take_period();
    int n = 0;
    while (!char_take) @(negedge clk);
    @(negedge clk);
    n = 1;
    while (!char_take) begin
      @(negedge clk);
      n++;
    end
    chk(n == 10, "R2", "take period", n, 10);
  endtask

  task automatic t_data(input logic [9:0] code, input bit fl, input string tag);
    logic [9:0] got;
    bit rd0, ez;
    xfer(1'b0, 8'h3C, 1'b0, code, fl, got, rd0, ez);
    chk(rd0 == exp_rd, tag, "rd at data take", rd0, exp_rd);
    chk(got == code, "R3", "data char bits", got, code);
    chk(!ez || (code == 10'h0), "R4", "payload forwarded", ez, 0);
    exp_rd = exp_rd ^ fl;
  endtask

  task automatic t_sync(input bit hold, input string tag);
    logic [9:0] got;
    bit rd0, ez, req;
    bit r = exp_rd;
    for (int k = 0; k < 16; k++) begin
      req = (k == 0) ? 1'b1 : (hold ? 1'b1 : k[0]);
      xfer(req, 8'hA0 + 8'(k), k[1], 10'h2AA ^ 10'(k), 1'b1, got, rd0, ez);
      chk(rd0 == exp_rd, "R10", "rd before run char", rd0, exp_rd);
      chk(ez, "R7", "payload masked", ez, 1);
      chk(got == kcode(kpol(k, r)), (k == 0) ? tag : "R6", "run char", got, kcode(kpol(k, r)));
      exp_rd = ~kpol(k, r);
    end
    chk(exp_rd == r, "R8", "model rd after run", exp_rd, r);
  endtask

  initial begin
    #(20 * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [9:0] got;
    bit rd0, ez;
    t_reset();
    t_take_period();
    t_data(10'h2E9, 1'b0, "R4");
    t_data(10'h1D5, 1'b1, "R4");
    t_data(10'h0F3, 1'b1, "R4");
    t_sync(1'b0, "R5");
    t_data(10'h155, 1'b0, "R8");
    t_data(10'h1A6, 1'b1, "R4");
    t_sync(1'b0, "R5");
    t_data(10'h333, 1'b0, "R9");
    t_sync(1'b1, "R5");
    t_sync(1'b1, "R9");
    xfer(1'b0, 8'h5A, 1'b1, 10'h0AB, 1'b1, got, rd0, ez);
    chk(got == 10'h0AB, "R9", "data after run", got, 10'h0AB);
    chk(rd0 == exp_rd, "R8", "rd after back-to-back", rd0, exp_rd);
    chk(!ez, "R7", "payload passes outside run", ez, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule